// File: doc/BRIEF.md
# Read-Only Serial Drain Port with Eight-Word Ring

This block gives an external serial controller a way to collect 16-bit words that on-chip receive logic has produced. Core-side logic hands a word in with a one-cycle push strobe, and the word lands in an eight-entry circular store. The controller drives its own serial clock and an active-low select, and gets one word back on the serial data output for every 16-clock frame. The port has no serial data input, so the controller can only read.

The serial side uses SPI mode 0. Data leaves most significant bit first. A new bit is launched on each falling edge, and the controller samples on each rising edge. The serial side runs with no fixed phase relation to the core clock. Each frame works on a head word that the core domain holds in a register. That register is reloaded only while the select line, seen through a synchronizer, is idle. The serial domain's read position goes back to the core as a Gray-coded pointer through a two-flop synchronizer.

The controller must keep select low for at least four core clocks before the first rising edge. It must also keep select high for at least six core clocks between frames.

Top module: `spi_rd_ring`

## Requirements
- R1: During a frame the output carries the head word most significant bit first. Bit 15 is valid from the falling edge of select, and each later bit is launched on a serial clock falling edge. The output enable `spi_miso_en_o` is 1 throughout the frame.
- R2: While select is high, `spi_miso_en_o` is 0, so the pad drives nothing.
- R3: A frame that sees 16 rising edges and then a rising select removes the head word. The next frame returns the next word in push order.
- R4: A frame that ends with fewer than 16 rising edges removes nothing. Zero edges counts as fewer. The next frame returns the same word again.
- R5: A frame started while the store is empty returns 0x0000 and removes nothing. A word pushed afterwards is the next word returned.
- R6: `not_empty_o` is 1 exactly when at least one word is held. It falls within six core clocks of the select rise that removes the last word.
- R7: With eight words held, `full_o` is 1. A push while full is discarded and sets `overflow_o`. The flag stays set until reset, and the eight stored words come out unchanged and in order.
- R8: After reset, `not_empty_o`, `full_o` and `overflow_o` are 0. Any words held before the reset are gone, so the next frame returns 0x0000.
- R9: Order is kept as the read and write positions wrap past the end of the store, after more than eight pushes in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock for the push side and the flags |
| rst_n_i | input | 1 | Asynchronous active-low reset; the core side releases it synchronously |
| push_i | input | 1 | One-cycle strobe that stores `push_data_i` |
| push_data_i | input | 16 | Word to store |
| not_empty_o | output | 1 | At least one word is held (core domain) |
| full_o | output | 1 | Eight words are held (core domain) |
| overflow_o | output | 1 | Sticky: a push was discarded because the store was full |
| spi_clk_i | input | 1 | Serial clock from the controller, idle low |
| spi_cs_n_i | input | 1 | Active-low frame select from the controller |
| spi_miso_o | output | 1 | Serial data to the controller |
| spi_miso_en_o | output | 1 | Output enable for the serial data pad |

## Verification
A read position that has slipped shows up on the very next full frame. That frame returns a word out of push order, or 0x0000 where data was expected, and `not_empty_o` goes wrong within about six core clocks of the select rise. A broken bit counter shows up in the same frame as a shifted or truncated word, or one frame later as a word that was popped twice or never popped. Corrupted write-side accounting shows up at the latest when the eighth or ninth push arrives: `full_o` or `overflow_o` takes the wrong value, and a drained word comes back different.

// File: rtl/spi_rd_ring_pkg.sv
package spi_rd_ring_pkg;

  localparam int unsigned RING_WORD_W = 16;
  localparam int unsigned RING_DEPTH  = 8;

  // Positions are at most 8 bits wide (depth up to 128).
  function automatic logic [7:0] to_gray(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [7:0] from_gray(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/rr_rst_sync.sv
module rr_rst_sync (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n_o = out_q;
endmodule

// File: rtl/rr_sync2.sv
module rr_sync2 #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rr_ring_store.sv
module rr_ring_store
  import spi_rd_ring_pkg::*;
#(
  parameter int unsigned WORD_W = RING_WORD_W,
  parameter int unsigned DEPTH  = RING_DEPTH,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned PTR_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic [PTR_W-1:0]  rd_gray_sync_i,
  input  logic              cs_idle_i,
  output logic [WORD_W-1:0] head_o,
  output logic              head_vld_o,
  output logic              not_empty_o,
  output logic              full_o,
  output logic              overflow_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_bin_q, wr_bin_d;
  logic [PTR_W-1:0]  rd_bin_c;
  logic [PTR_W-1:0]  level_c;
  logic              empty_c, full_c, push_ok_c;
  logic              ovf_q, ovf_d;
  logic [WORD_W-1:0] head_q, head_d;
  logic              head_vld_q, head_vld_d;

  // Read position arrives Gray coded; convert once per cycle.
  always_comb begin
    rd_bin_c = PTR_W'(from_gray(8'(rd_gray_sync_i)));
    level_c  = wr_bin_q - rd_bin_c;
    empty_c  = (wr_bin_q == rd_bin_c);
    full_c   = (level_c == PTR_W'(DEPTH));
    push_ok_c = push_i && !full_c;
  end

  // Next-state logic
  always_comb begin
    wr_bin_d   = wr_bin_q;
    ovf_d      = ovf_q;
    head_d     = head_q;
    head_vld_d = head_vld_q;
    if (push_ok_c) begin
      wr_bin_d = wr_bin_q + PTR_W'(1);
    end
    if (push_i && full_c) begin
      ovf_d = 1'b1;
    end
    // Head is frozen while the serial side is inside a frame.
    if (cs_idle_i) begin
      head_vld_d = !empty_c;
      head_d     = empty_c ? '0 : mem_q[rd_bin_c[ADDR_W-1:0]];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wr_bin_q   <= '0;
      ovf_q      <= 1'b0;
      head_q     <= '0;
      head_vld_q <= 1'b0;
    end else begin
      wr_bin_q   <= wr_bin_d;
      ovf_q      <= ovf_d;
      head_q     <= head_d;
      head_vld_q <= head_vld_d;
    end
  end

  // Storage array: no reset, write enable spelled out.
  always_ff @(posedge clk_i) begin
    if (push_ok_c) begin
      mem_q[wr_bin_q[ADDR_W-1:0]] <= push_data_i;
    end
  end

  assign head_o      = head_q;
  assign head_vld_o  = head_vld_q;
  assign not_empty_o = !empty_c;
  assign full_o      = full_c;
  assign overflow_o  = ovf_q;
endmodule

// File: rtl/rr_spi_shift.sv
module rr_spi_shift
  import spi_rd_ring_pkg::*;
#(
  parameter int unsigned WORD_W = RING_WORD_W,
  parameter int unsigned DEPTH  = RING_DEPTH,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned PTR_W  = ADDR_W + 1,
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              spi_clk_i,
  input  logic              cs_n_i,
  input  logic              rst_n_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic              head_vld_i,
  output logic              miso_o,
  output logic              miso_en_o,
  output logic [PTR_W-1:0]  rd_gray_o
);
  logic              frame_clr;
  logic [CNT_W-1:0]  rise_cnt_q, rise_cnt_d;
  logic [CNT_W-1:0]  idx_q;
  logic              frame_full_c;
  logic              pop_c;
  logic [PTR_W-1:0]  rd_bin_q, rd_bin_d;
  logic [PTR_W-1:0]  rd_gray_q, rd_gray_d;
  logic [WORD_W-1:0] shifted_c;

  // The serial clock stops while idle, so this domain takes reset asynchronously.
  assign frame_clr = cs_n_i | ~rst_n_i;

  always_comb begin
    frame_full_c = (rise_cnt_q == CNT_W'(WORD_W));
    rise_cnt_d   = frame_full_c ? rise_cnt_q : rise_cnt_q + CNT_W'(1);
  end

  // Count sampling edges within a frame.
  always_ff @(posedge spi_clk_i or posedge frame_clr) begin
    if (frame_clr) begin
      rise_cnt_q <= '0;
    end else begin
      rise_cnt_q <= rise_cnt_d;
    end
  end

  // Launch the next bit on the falling edge.
  always_ff @(negedge spi_clk_i or posedge frame_clr) begin
    if (frame_clr) begin
      idx_q <= '0;
    end else begin
      idx_q <= rise_cnt_q;
    end
  end

  // Read position moves when select rises after a complete frame.
  always_comb begin
    pop_c     = frame_full_c && head_vld_i;
    rd_bin_d  = pop_c ? rd_bin_q + PTR_W'(1) : rd_bin_q;
    rd_gray_d = PTR_W'(to_gray(8'(rd_bin_d)));
  end

  always_ff @(posedge cs_n_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
    end else begin
      rd_bin_q  <= rd_bin_d;
      rd_gray_q <= rd_gray_d;
    end
  end

  assign shifted_c = head_i << idx_q;
  assign miso_o    = shifted_c[WORD_W-1];
  assign miso_en_o = ~cs_n_i;
  assign rd_gray_o = rd_gray_q;
endmodule

// File: rtl/spi_rd_ring.sv
module spi_rd_ring
  import spi_rd_ring_pkg::*;
#(
  parameter int unsigned WORD_W = RING_WORD_W,
  parameter int unsigned DEPTH  = RING_DEPTH,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned PTR_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  output logic              not_empty_o,
  output logic              full_o,
  output logic              overflow_o,
  input  logic              spi_clk_i,
  input  logic              spi_cs_n_i,
  output logic              spi_miso_o,
  output logic              spi_miso_en_o
);
  logic              rst_core_n;
  logic              cs_idle_sync;
  logic [PTR_W-1:0]  rd_gray_spi;
  logic [PTR_W-1:0]  rd_gray_sync;
  logic [WORD_W-1:0] head_word;
  logic              head_vld;

  rr_rst_sync u_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (rst_n_i),
    .srst_n_o (rst_core_n)
  );

  rr_sync2 #(.W(1), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_core_n),
    .d_i     (spi_cs_n_i),
    .q_o     (cs_idle_sync)
  );

  rr_sync2 #(.W(PTR_W), .RST_VAL(1'b0)) u_rd_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_core_n),
    .d_i     (rd_gray_spi),
    .q_o     (rd_gray_sync)
  );

  rr_ring_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk_i          (clk_i),
    .rst_n_i        (rst_core_n),
    .push_i         (push_i),
    .push_data_i    (push_data_i),
    .rd_gray_sync_i (rd_gray_sync),
    .cs_idle_i      (cs_idle_sync),
    .head_o         (head_word),
    .head_vld_o     (head_vld),
    .not_empty_o    (not_empty_o),
    .full_o         (full_o),
    .overflow_o     (overflow_o)
  );

  rr_spi_shift #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_shift (
    .spi_clk_i  (spi_clk_i),
    .cs_n_i     (spi_cs_n_i),
    .rst_n_i    (rst_n_i),
    .head_i     (head_word),
    .head_vld_i (head_vld),
    .miso_o     (spi_miso_o),
    .miso_en_o  (spi_miso_en_o),
    .rd_gray_o  (rd_gray_spi)
  );
endmodule

// File: rtl/spi_rd_ring_chk.sv
module spi_rd_ring_chk #(
  parameter int unsigned PTR_W = 4
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             push_i,
  input logic             full_i,
  input logic             not_empty_i,
  input logic             overflow_i,
  input logic [PTR_W-1:0] rd_gray_i
);
  // Each pop moves the read position by one Gray step, so at most one bit flips.
  assert_gray_step_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $countones(rd_gray_i ^ $past(rd_gray_i)) <= 1);

  assert_full_has_data_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    full_i |-> not_empty_i);

  assert_overflow_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    overflow_i |=> overflow_i);

  assert_overflow_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(overflow_i) |-> $past(push_i && full_i));

  assert_empty_not_full_next_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !not_empty_i |=> !full_i);
endmodule

bind spi_rd_ring spi_rd_ring_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_core_n),
  .push_i      (push_i),
  .full_i      (full_o),
  .not_empty_i (not_empty_o),
  .overflow_i  (overflow_o),
  .rd_gray_i   (rd_gray_sync)
);

// File: tb/test_spi_rd_ring.sv
module test_spi_rd_ring;
  logic        clk;
  logic        rst_n;
  logic        push;
  logic [15:0] push_data;
  logic        not_empty, full, overflow;
  logic        sclk, cs_n, miso, miso_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  spi_rd_ring i_spi_rd_ring (
    .clk_i         (clk),
    .rst_n_i       (rst_n),
    .push_i        (push),
    .push_data_i   (push_data),
    .not_empty_o   (not_empty),
    .full_o        (full),
    .overflow_o    (overflow),
    .spi_clk_i     (sclk),
    .spi_cs_n_i    (cs_n),
    .spi_miso_o    (miso),
    .spi_miso_en_o (miso_en)
  );

  // 250 MHz core clock; edges at odd ns, serial events at even ns.
  initial begin
    clk = 1'b0;
    #1;
    forever #2 clk = ~clk;
  end

  typedef struct packed {
    logic        is_xfer;
    logic [4:0]  nbits;
    logic [15:0] word;   // push data or expected frame word
    logic        exp_ne;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd16, 16'h0000, 1'b0},  // R5 empty read
    '{1'b0, 5'd0,  16'hA5C3, 1'b1},
    '{1'b1, 5'd16, 16'hA5C3, 1'b0},  // R1 R3
    '{1'b0, 5'd0,  16'h1234, 1'b1},
    '{1'b0, 5'd0,  16'h8001, 1'b1},
    '{1'b1, 5'd7,  16'h1234, 1'b1},  // R4 short
    '{1'b1, 5'd0,  16'h1234, 1'b1},  // R4 no clocks
    '{1'b1, 5'd16, 16'h1234, 1'b1},  // R4 same word
    '{1'b1, 5'd16, 16'h8001, 1'b0},  // R3 R6
    '{1'b1, 5'd16, 16'h0000, 1'b0},  // R5
    '{1'b0, 5'd0,  16'hFFFF, 1'b1},
    '{1'b1, 5'd16, 16'hFFFF, 1'b0},
    '{1'b0, 5'd0,  16'h0F0F, 1'b1},
    '{1'b1, 5'd16, 16'h0F0F, 1'b0}   // R5 push after empty
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_push(input logic [15:0] w);
    @(negedge clk);
    push      = 1'b1;
    push_data = w;
    @(negedge clk);
    push      = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic spi_xfer(input int nbits, output logic [15:0] rx, output bit en_ok);
    @(negedge clk);
    #1;
    en_ok = !miso_en;
    rx    = '0;
    cs_n  = 1'b0;
    #40;
    for (int i = 0; i < nbits; i++) begin
      rx = {rx[14:0], miso};
      if (!miso_en) en_ok = 1'b0;
      sclk = 1'b1;
      #10;
      sclk = 1'b0;
      #10;
    end
    cs_n = 1'b1;
    #2;
    if (miso_en) en_ok = 1'b0;
    #58;
  endtask

  task automatic read_expect(input logic [15:0] exp, input string req);
    logic [15:0] rx;
    bit          en_ok;
    spi_xfer(16, rx, en_ok);
    check(rx == exp, req, 32'(rx), 32'(exp));
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    bit          en_ok;
    rst_n = 1'b0; push = 1'b0; push_data = '0; sclk = 1'b0; cs_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset state
    check(!not_empty, "R8 not_empty", 32'(not_empty), 0);
    check(!full,      "R8 full",      32'(full), 0);
    check(!overflow,  "R8 overflow",  32'(overflow), 0);
    check(!miso_en,   "R2 idle enable", 32'(miso_en), 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].is_xfer) begin
        spi_xfer(int'(VEC[v].nbits), rx, en_ok);
        check(rx == (VEC[v].word >> (16 - int'(VEC[v].nbits))), "R1 R3 R4 R5 frame data",
              32'(rx), 32'(VEC[v].word >> (16 - int'(VEC[v].nbits))));
        check(en_ok, "R1 R2 output enable", 32'(en_ok), 1);
      end else begin
        do_push(VEC[v].word);
      end
      repeat (4) @(negedge clk);
      check(not_empty == VEC[v].exp_ne, "R6 not_empty", 32'(not_empty), 32'(VEC[v].exp_ne));
    end

    // R7 fill, overflow, drain in order
    for (int i = 0; i < 8; i++) do_push(16'h3000 + 16'(i));
    check(full, "R7 full after eight", 32'(full), 1);
    check(!overflow, "R7 no overflow yet", 32'(overflow), 0);
    do_push(16'hDEAD);
    check(overflow, "R7 overflow set", 32'(overflow), 1);
    check(full, "R7 still full", 32'(full), 1);
    for (int i = 0; i < 8; i++) read_expect(16'h3000 + 16'(i), "R7 drained word");
    read_expect(16'h0000, "R7 dropped word absent");
    repeat (4) @(negedge clk);
    check(!not_empty, "R6 empty after drain", 32'(not_empty), 0);
    check(!full, "R7 not full after drain", 32'(full), 0);
    check(overflow, "R7 overflow sticky", 32'(overflow), 1);

    // R9 wrap: positions pass the end of the store again
    for (int i = 0; i < 6; i++) do_push(16'hC100 + 16'(i * 3));
    for (int i = 0; i < 6; i++) read_expect(16'hC100 + 16'(i * 3), "R9 wrapped order");

    // R8 reset mid-state clears words and sticky flag
    do_push(16'h5555);
    do_push(16'h6666);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!not_empty, "R8 not_empty after reset", 32'(not_empty), 0);
    check(!overflow, "R8 overflow cleared", 32'(overflow), 0);
    read_expect(16'h0000, "R8 words discarded");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule